// File: doc/BRIEF.md
# Video Bank Address Mapper

This block sits between a video controller and the system memory. The video controller emits a 14-bit fetch address, which reaches only 16 KB. The mapper widens it to a 16-bit system address by choosing one of four 16 KB banks. The bank choice comes from the two lowest bits of a peripheral output port, and the port's data and direction registers are kept inside this block. A window of the mapped space holds the character ROM instead of main RAM. Each video fetch is steered to exactly one of the two devices, and the byte that comes back is returned.

The block keeps a copy of the last byte seen on the data bus and the last address driven. Colour fetches read a 4-bit colour memory, so they change only the low nibble of that held byte. The high nibble keeps whatever value the bus last carried. RAM, ROM, colour memory and the video controller are outside the block; their read data arrives in the same cycle as the request.

Top module: `vbank_mapper`

## Requirements
- R1: After reset the held bus byte `rd_data` is 0xFF, `last_addr` is 0xFFFF, `rd_valid` is 0, and both port registers read as all ones, so the bank base is 0x0000.
- R2: The bank base follows the two low port bits inverted: 11 gives 0x0000, 10 gives 0x4000, 01 gives 0x8000 and 00 gives 0xC000.
- R3: While `vid_req` is high, `mem_addr` equals `vid_addr` ORed with the current bank base, in the same cycle.
- R4: A video fetch selects the character ROM (`rom_sel`) when `mem_addr & 0x7000` equals 0x1000, and selects RAM (`ram_sel`) otherwise. This means ROM appears only in the banks at 0x0000 and 0x8000. `rom_addr` carries `mem_addr[11:0]`. Neither select is high without `vid_req`.
- R5: A port data write (`port_wr`) changes only the port bits whose direction bit is 1. A direction write (`dir_wr`) replaces the direction register. When both writes happen in one cycle, the data write uses the old direction value.
- R6: A fetch in the same cycle as a port write uses the old bank. The new bank applies from the next cycle onward.
- R7: In the cycle after a video fetch, `rd_valid` is 1, `rd_data` holds the selected device's byte, and `last_addr` holds that fetch's `mem_addr`.
- R8: In the cycle after a colour fetch (`col_req` without `vid_req`), `rd_data[7:4]` keeps its previous value and `rd_data[3:0]` equals `col_data`. `last_addr` becomes `vid_addr` zero-extended, with no bank applied. `rd_valid` is 1.
- R9: When `vid_req` and `col_req` are both high, only the video fetch is served.
- R10: In a cycle with no request, `rd_data` and `last_addr` are unchanged in the next cycle and `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_wr | input | 1 | Write strobe for the port data register |
| dir_wr | input | 1 | Write strobe for the port direction register |
| cfg_wdata | input | 8 | Write data for both port registers |
| vid_req | input | 1 | Video fetch strobe |
| col_req | input | 1 | Colour fetch strobe |
| vid_addr | input | 14 | Video fetch address (also used as the colour address) |
| col_data | input | 4 | Colour memory read nibble |
| ram_rdata | input | 8 | Main RAM read byte |
| rom_rdata | input | 8 | Character ROM read byte |
| mem_addr | output | 16 | Mapped system address |
| ram_sel | output | 1 | Main RAM select |
| rom_sel | output | 1 | Character ROM select |
| rom_addr | output | 12 | Character ROM address |
| rd_valid | output | 1 | The returned byte was updated in the previous cycle |
| rd_data | output | 8 | Held bus byte |
| last_addr | output | 16 | Held last address |

## Verification
If the held bank register is wrong, the first video fetch after it goes wrong shows the error. The top two bits of `mem_addr` are wrong in that same cycle, and the ROM/RAM steering may flip. If the port or direction registers are corrupted, nothing shows until a later port write combines with them, and then the error appears as a wrong bank one cycle later. If the held bus byte is wrong, the next colour fetch shows it in the upper nibble of `rd_data` one cycle after the strobe. For that reason the bench keeps colour fetches interleaved with ordinary fetches.

// File: rtl/vbm_pkg.sv
package vbm_pkg;
  localparam int VADDR_W = 14;
  localparam int SADDR_W = 16;
  localparam int DATA_W  = 8;
  localparam int COL_W   = 4;
  localparam int ROMA_W  = 12;
  localparam int PORT_W  = 8;

  // Bank field is the inverse of the port selector bits.
  function automatic logic [SADDR_W-VADDR_W-1:0] bank_from_port(
    input logic [SADDR_W-VADDR_W-1:0] sel);
    return ~sel;
  endfunction
endpackage

// File: rtl/vbm_bank_reg.sv
module vbm_bank_reg
  import vbm_pkg::*;
#(
  parameter int PW     = PORT_W,
  parameter int BANK_W = SADDR_W - VADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_wr,
  input  logic              dir_wr,
  input  logic [PW-1:0]     wdata,
  output logic [BANK_W-1:0] bank
);
  logic [PW-1:0]     port_q, port_d;
  logic [PW-1:0]     dir_q,  dir_d;
  logic [BANK_W-1:0] bank_q, bank_d;

  always_comb begin
    port_d = port_q;
    dir_d  = dir_q;
    bank_d = bank_q;
    if (port_wr) begin
      port_d = (port_q & ~dir_q) | (wdata & dir_q);
      bank_d = bank_from_port(port_d[BANK_W-1:0]);
    end
    if (dir_wr) dir_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= '1;
      dir_q  <= '1;
      bank_q <= bank_from_port('1);
    end else begin
      if (port_wr) port_q <= port_d;
      if (port_wr) bank_q <= bank_d;
      if (dir_wr)  dir_q  <= dir_d;
    end
  end

  assign bank = bank_q;
endmodule

// File: rtl/vbm_decode.sv
module vbm_decode
  import vbm_pkg::*;
#(
  parameter int VW = VADDR_W,
  parameter int SW = SADDR_W,
  parameter int DW = DATA_W,
  parameter int RW = ROMA_W,
  parameter logic [SW-1:0] OVL_MASK  = 16'h7000,
  parameter logic [SW-1:0] OVL_MATCH = 16'h1000,
  localparam int BW = SW - VW
) (
  input  logic [BW-1:0] bank,
  input  logic          vid_req,
  input  logic [VW-1:0] vid_addr,
  input  logic [DW-1:0] ram_rdata,
  input  logic [DW-1:0] rom_rdata,
  output logic [SW-1:0] mem_addr,
  output logic          ram_sel,
  output logic          rom_sel,
  output logic [RW-1:0] rom_addr,
  output logic [DW-1:0] fetch_data
);
  logic [SW-1:0] base;
  logic          overlay;

  always_comb begin
    base       = {bank, {VW{1'b0}}};
    mem_addr   = base | {{BW{1'b0}}, vid_addr};
    overlay    = (mem_addr & OVL_MASK) == OVL_MATCH;
    rom_sel    = vid_req & overlay;
    ram_sel    = vid_req & ~overlay;
    rom_addr   = mem_addr[RW-1:0];
    fetch_data = overlay ? rom_rdata : ram_rdata;
  end
endmodule

// File: rtl/vbm_bus_hold.sv
module vbm_bus_hold
  import vbm_pkg::*;
#(
  parameter int VW = VADDR_W,
  parameter int SW = SADDR_W,
  parameter int DW = DATA_W,
  parameter int CW = COL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vid_req,
  input  logic          col_req,
  input  logic [SW-1:0] fetch_addr,
  input  logic [DW-1:0] fetch_data,
  input  logic [VW-1:0] col_addr,
  input  logic [CW-1:0] col_data,
  output logic          valid,
  output logic [DW-1:0] bus,
  output logic [SW-1:0] addr
);
  logic [DW-1:0] bus_q,  bus_d;
  logic [SW-1:0] addr_q, addr_d;
  logic          valid_q, valid_d;
  logic          upd;

  always_comb begin
    upd     = vid_req | col_req;
    valid_d = upd;
    bus_d   = bus_q;
    addr_d  = addr_q;
    if (vid_req) begin
      bus_d  = fetch_data;
      addr_d = fetch_addr;
    end else if (col_req) begin
      bus_d  = {bus_q[DW-1:CW], col_data};
      addr_d = {{(SW-VW){1'b0}}, col_addr};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q   <= '1;
      addr_q  <= '1;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (upd) begin
        bus_q  <= bus_d;
        addr_q <= addr_d;
      end
    end
  end

  assign valid = valid_q;
  assign bus   = bus_q;
  assign addr  = addr_q;
endmodule

// File: rtl/vbank_mapper.sv
module vbank_mapper
  import vbm_pkg::*;
#(
  parameter int VW = VADDR_W,
  parameter int SW = SADDR_W,
  parameter int DW = DATA_W,
  parameter int CW = COL_W,
  parameter int RW = ROMA_W,
  parameter int PW = PORT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          port_wr,
  input  logic          dir_wr,
  input  logic [PW-1:0] cfg_wdata,
  input  logic          vid_req,
  input  logic          col_req,
  input  logic [VW-1:0] vid_addr,
  input  logic [CW-1:0] col_data,
  input  logic [DW-1:0] ram_rdata,
  input  logic [DW-1:0] rom_rdata,
  output logic [SW-1:0] mem_addr,
  output logic          ram_sel,
  output logic          rom_sel,
  output logic [RW-1:0] rom_addr,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [SW-1:0] last_addr
);
  localparam int BW = SW - VW;

  logic [BW-1:0] bank;
  logic [DW-1:0] fetch_data;

  vbm_bank_reg #(.PW(PW), .BANK_W(BW)) u_bank (
    .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .dir_wr(dir_wr),
    .wdata(cfg_wdata), .bank(bank));

  vbm_decode #(.VW(VW), .SW(SW), .DW(DW), .RW(RW)) u_dec (
    .bank(bank), .vid_req(vid_req), .vid_addr(vid_addr),
    .ram_rdata(ram_rdata), .rom_rdata(rom_rdata), .mem_addr(mem_addr),
    .ram_sel(ram_sel), .rom_sel(rom_sel), .rom_addr(rom_addr),
    .fetch_data(fetch_data));

  vbm_bus_hold #(.VW(VW), .SW(SW), .DW(DW), .CW(CW)) u_hold (
    .clk(clk), .rst_n(rst_n), .vid_req(vid_req), .col_req(col_req),
    .fetch_addr(mem_addr), .fetch_data(fetch_data), .col_addr(vid_addr),
    .col_data(col_data), .valid(rd_valid), .bus(rd_data), .addr(last_addr));
endmodule

// File: rtl/vbm_checker.sv
module vbm_checker #(
  parameter int VW = 14,
  parameter int SW = 16,
  parameter int DW = 8,
  parameter int CW = 4,
  parameter int RW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vid_req,
  input logic          col_req,
  input logic [VW-1:0] vid_addr,
  input logic [CW-1:0] col_data,
  input logic [SW-1:0] mem_addr,
  input logic          ram_sel,
  input logic          rom_sel,
  input logic [RW-1:0] rom_addr,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data,
  input logic [SW-1:0] last_addr
);
  p_low_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vid_req |-> mem_addr[VW-1:0] == vid_addr);

  p_one_device_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_sel, rom_sel}) && ((ram_sel || rom_sel) == vid_req));

  p_rom_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> (mem_addr[14:12] == 3'b001 && rom_addr == mem_addr[RW-1:0]));

  p_fetch_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vid_req |=> (rd_valid && last_addr == $past(mem_addr)));

  p_colour_merge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (col_req && !vid_req) |=>
      (rd_data[DW-1:CW] == $past(rd_data[DW-1:CW]) && rd_data[CW-1:0] == $past(col_data)));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!vid_req && !col_req) |=> (!rd_valid && $stable(rd_data) && $stable(last_addr)));
endmodule

bind vbank_mapper vbm_checker #(.VW(VW), .SW(SW), .DW(DW), .CW(CW), .RW(RW)) i_vbm_checker (
  .clk(clk), .rst_n(rst_n), .vid_req(vid_req), .col_req(col_req),
  .vid_addr(vid_addr), .col_data(col_data), .mem_addr(mem_addr),
  .ram_sel(ram_sel), .rom_sel(rom_sel), .rom_addr(rom_addr),
  .rd_valid(rd_valid), .rd_data(rd_data), .last_addr(last_addr));

// File: tb/test_vbank_mapper.sv
`timescale 1ns/1ps
module test_vbank_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        port_wr = 0, dir_wr = 0, vid_req = 0, col_req = 0;
  logic [7:0]  cfg_wdata = 0;
  logic [13:0] vid_addr = 0;
  logic [3:0]  col_data = 0;
  logic [7:0]  ram_rdata, rom_rdata;
  logic [15:0] mem_addr, last_addr;
  logic        ram_sel, rom_sel, rd_valid;
  logic [11:0] rom_addr;
  logic [7:0]  rd_data;

  int tests = 0, fails = 0;
  int m_port = 255, m_dir = 255, m_bus = 255, m_last = 65535, m_valid = 0;

  always #4 clk = ~clk;

  // memory models: data derived from the address
  assign ram_rdata = mem_addr[7:0] ^ mem_addr[15:8] ^ 8'h5A;
  assign rom_rdata = ~(rom_addr[7:0] + {4'h0, rom_addr[11:8]});

  vbank_mapper i_vbank_mapper (
    .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .dir_wr(dir_wr),
    .cfg_wdata(cfg_wdata), .vid_req(vid_req), .col_req(col_req),
    .vid_addr(vid_addr), .col_data(col_data), .ram_rdata(ram_rdata),
    .rom_rdata(rom_rdata), .mem_addr(mem_addr), .ram_sel(ram_sel),
    .rom_sel(rom_sel), .rom_addr(rom_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .last_addr(last_addr));

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int base_of(input int p);
    case (p & 3)
      0: return 'hC000;
      1: return 'h8000;
      2: return 'h4000;
      default: return 'h0000;
    endcase
  endfunction

  // Called at a negedge; drives one cycle, checks comb then registered outputs.
  task automatic step(input bit pw, input bit dw, input int wd, input bit vr,
                      input bit cr, input int va, input int cd);
    int addr, is_rom, exp_data;
    port_wr = pw; dir_wr = dw; cfg_wdata = wd[7:0];
    vid_req = vr; col_req = cr; vid_addr = va[13:0]; col_data = cd[3:0];
    #1;
    addr   = base_of(m_port) | (va & 'h3FFF);
    is_rom = ((addr & 'h7000) == 'h1000);
    exp_data = is_rom ? ((~((addr & 'hFF) + ((addr >> 8) & 'hF))) & 'hFF)
                      : (((addr & 'hFF) ^ (addr >> 8) ^ 'h5A) & 'hFF);
    if (vr) begin
      check("R3 mem_addr", mem_addr, addr);
      check("R2 bank base", mem_addr & 'hC000, base_of(m_port));
      check("R4 rom_sel", rom_sel, is_rom);
      check("R4 ram_sel", ram_sel, !is_rom);
      if (is_rom) check("R4 rom_addr", rom_addr, addr & 'hFFF);
    end else begin
      check("R4 no select when idle", {ram_sel, rom_sel}, 0);
    end
    @(posedge clk);
    // model update with pre-edge values
    if (vr) begin
      m_bus = exp_data; m_last = addr;
    end else if (cr) begin  // R9: video wins when both set
      m_bus = (m_bus & 'hF0) | (cd & 'hF); m_last = va & 'h3FFF;
    end
    m_valid = vr | cr;
    if (pw) m_port = (m_port & ~m_dir & 'hFF) | (wd & m_dir & 'hFF);  // R5
    if (dw) m_dir = wd & 'hFF;
    @(negedge clk);
    check(vr ? "R7 rd_data" : (cr ? "R8 rd_data" : "R10 rd_data"), rd_data, m_bus);
    check(vr ? "R7 last_addr" : (cr ? "R8 last_addr" : "R10 last_addr"), last_addr, m_last);
    check("R7 rd_valid", rd_valid, m_valid);
    port_wr = 0; dir_wr = 0; vid_req = 0; col_req = 0;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rd_data", rd_data, 'hFF);
    check("R1 last_addr", last_addr, 'hFFFF);
    check("R1 rd_valid", rd_valid, 0);
    rst_n = 1;
    @(negedge clk);
    // R1 bank base 0 after reset; R4 overlay boundaries in bank 0
    step(0,0,0, 1,0, 'h0123, 0);
    step(0,0,0, 1,0, 'h1000, 0);
    step(0,0,0, 1,0, 'h1FFF, 0);
    step(0,0,0, 1,0, 'h2000, 0);
    step(0,0,0, 1,0, 'h0FFF, 0);
    // R2 every bank; overlay presence in each
    for (int p = 0; p < 4; p++) begin
      step(1,0,p, 0,0, 0, 0);
      step(0,0,0, 1,0, 'h1234, 0);
      step(0,0,0, 1,0, 'h3ABC, 0);
    end
    // R6 fetch in same cycle as port write uses old bank (now port=3)
    step(1,0,'h00, 1,0, 'h1111, 0);
    step(0,0,0, 1,0, 'h1111, 0);
    // R5 direction mask: only bit 1 writable
    step(0,1,'h02, 0,0, 0, 0);
    step(1,0,'hFD, 1,0, 'h0500, 0);
    step(0,0,0, 1,0, 'h1500, 0);
    // R5 same-cycle data and direction writes
    step(1,1,'hFF, 0,0, 0, 0);
    step(0,0,0, 1,0, 'h1500, 0);
    // R8 colour fetches keep upper nibble
    step(0,0,0, 1,0, 'h00F3, 0);
    step(0,0,0, 0,1, 'h03FF, 'hA);
    step(0,0,0, 0,1, 'h0001, 'h3);
    // R9 both requests
    step(0,0,0, 1,1, 'h2222, 'h7);
    // R10 idle
    step(0,0,0, 0,0, 'h1234, 'h9);
    step(0,0,0, 0,0, 0, 0);
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom;
      step(r[0] & r[1], r[2] & r[3] & r[4], $urandom & 'hFF,
           r[5] | r[6], r[7], $urandom & 'h3FFF, $urandom & 'hF);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule